// File: doc/BRIEF.md
# Multi-CPU Private Peripheral Window Decoder

This block sits in front of the private peripherals of a cluster of up to four processors. It decodes a 4 KB window from the low twelve bits of the access address and sends each access to one of three places. The first is a tiny snoop-control register set held inside the block. The second is the interrupt CPU interface slot of one processor. The third is the timer or watchdog slot of one processor. Interrupt and timer slots can be reached two ways. A banked page follows the ID of the processor that issues the access. A set of aliased pages, one per processor, names the target processor directly by address.

The decoder drives a target index, a local register offset and one-hot write enables toward the interrupt-interface and timer register banks. Those banks return their read data combinationally. The decoder selects that data and registers it, so read data appears one cycle after the read strobe. Inside a timer page a single address bit picks the watchdog instance rather than the timer. For the selected instance the block also reports the private interrupt number it raises. Aliases that name a processor beyond the configured count, snoop-control offsets that are not decoded, and pages past the last timer alias all read as zero and write nothing. The last two also pulse an error flag.

Top module: `prv_window_dec`

## Requirements
- R1: Address bits above bit 11 are ignored. An access at 0x7654_3134 behaves exactly like one at 0x134.
- R2: The snoop-control word at window offset 0x000 keeps only bit 0 of a write. Its other bits read as zero, and it is zero after reset.
- R3: The configuration word at offset 0x004 reads as (((1<<N)-1)<<4) | (N-1), where N is the NUM_CPU parameter. For N=3 this is 0x72.
- R4: The CPU-status word at 0x008 and the invalidate-all word at 0x00C read as zero. A write to 0x00C leaves the snoop-control word unchanged.
- R5: Offsets 0x100–0x1FF target the interrupt interface of the requesting CPU. irq_idx equals acc_cpu, irq_off equals address bits [7:0], and a write sets only bit irq_idx of irq_we.
- R6: Offsets 0x200 + k*0x100 (k = 0..3) target the interrupt interface of CPU k, with irq_idx = k and irq_off = address bits [7:0].
- R7: Offsets 0x600–0x6FF target the timer page of the requesting CPU, and 0x700 + k*0x100 targets that of CPU k. tmr_idx = cpu*2 + address bit 5 and tmr_off = address bits [3:0]. A write sets only bit tmr_idx of tmr_we.
- R8: tmr_irq_id is 29 when address bit 5 is 0 (timer) and 30 when it is 1 (watchdog).
- R9: An aliased interrupt or timer page naming CPU k >= N reads as zero and raises no write enable.
- R10: Snoop-control offsets other than 0x00/0x04/0x08/0x0C, and window offsets 0xB00–0xFFF, read as zero and raise no write enable. acc_err is high for exactly the cycle after each such access.
- R11: rd_valid and rd_data are registered. They carry the result in the cycle after a read strobe. In every other cycle rd_valid is 0 and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_cpu | input | CPU_W | ID of the requesting CPU |
| acc_addr | input | ADDR_W | Access address; only bits [11:0] are decoded |
| acc_wdata | input | DATA_W | Write data; bit 0 feeds the snoop-control word |
| irq_rdata | input | DATA_W | Read data from the selected interrupt-interface slot |
| tmr_rdata | input | DATA_W | Read data from the selected timer/watchdog slot |
| rd_valid | output | 1 | Registered read-data valid |
| rd_data | output | DATA_W | Registered read data |
| acc_err | output | 1 | One-cycle pulse after an undecoded access |
| irq_idx | output | CPU_W | Target CPU of an interrupt-interface access |
| irq_off | output | 8 | Local offset inside the interrupt-interface slot |
| irq_we | output | MAX_CPU | One-hot write enable per interrupt-interface slot |
| tmr_idx | output | CPU_W+1 | Timer instance index, cpu*2 + watchdog select |
| tmr_off | output | 4 | Register offset inside the timer instance |
| tmr_we | output | 2*MAX_CPU | One-hot write enable per timer instance |
| tmr_irq_id | output | 5 | Private interrupt number of the selected instance |

## Verification
The hardest situation to reach is an aliased page that names a processor which exists in the address map but not in the configuration. With the default of four CPUs, every alias page is populated. The bench therefore builds the block with three CPUs, so the fourth alias page in each region decodes but must stay inert. To show that a blocked write really changed nothing, the bench reads the same slot back through the banked page, with the requesting ID set to the missing processor. The stub register must still hold its reset value.

// File: rtl/prv_pkg.sv
package prv_pkg;

  typedef enum logic [1:0] {
    RG_SCU  = 2'd0,
    RG_IRQ  = 2'd1,
    RG_TMR  = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  localparam int PAGE_W  = 4;
  localparam int LOCAL_W = 8;
  localparam int TREG_W  = 4;
  localparam int SEL_BIT = 5;

  localparam logic [LOCAL_W-1:0] SCU_CTRL = 8'h00;
  localparam logic [LOCAL_W-1:0] SCU_CFG  = 8'h04;
  localparam logic [LOCAL_W-1:0] SCU_STAT = 8'h08;
  localparam logic [LOCAL_W-1:0] SCU_INV  = 8'h0C;

  localparam logic [4:0] PPI_TIMER = 5'd29;
  localparam logic [4:0] PPI_WDOG  = 5'd30;

endpackage

// File: rtl/prv_region_decode.sv
module prv_region_decode #(
  parameter int MAX_CPU = 4,
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input  logic [11:0]      win_addr,
  input  logic [CPU_W-1:0] req_cpu,
  output prv_pkg::region_e region,
  output logic [CPU_W-1:0] cpu,
  output logic             cpu_ok,
  output logic [7:0]       off,
  output logic             sel
);
  import prv_pkg::*;

  // Page numbers (address bits [11:8]) derived from the CPU count.
  localparam logic [4:0] PG_IRQ_BANK  = 5'd1;
  localparam logic [4:0] PG_IRQ_ALIAS = 5'd2;
  localparam logic [4:0] PG_TMR_BANK  = 5'(2 + MAX_CPU);
  localparam logic [4:0] PG_TMR_ALIAS = 5'(3 + MAX_CPU);
  localparam logic [4:0] PG_END       = 5'(3 + 2 * MAX_CPU);
  localparam logic [4:0] N_CPU        = 5'(NUM_CPU);

  logic [4:0] page;
  logic [4:0] irq_alias_cpu;
  logic [4:0] tmr_alias_cpu;

  assign page          = {1'b0, win_addr[11:8]};
  assign irq_alias_cpu = page - PG_IRQ_ALIAS;
  assign tmr_alias_cpu = page - PG_TMR_ALIAS;

  always_comb begin
    region = RG_NONE;
    cpu    = '0;
    cpu_ok = 1'b0;
    if (page == 5'd0) begin
      region = RG_SCU;
      cpu_ok = 1'b1;
    end else if (page == PG_IRQ_BANK) begin
      region = RG_IRQ;
      cpu    = req_cpu;
      cpu_ok = 1'b1;
    end else if (page < PG_TMR_BANK) begin
      region = RG_IRQ;
      cpu    = irq_alias_cpu[CPU_W-1:0];
      cpu_ok = (irq_alias_cpu < N_CPU);
    end else if (page == PG_TMR_BANK) begin
      region = RG_TMR;
      cpu    = req_cpu;
      cpu_ok = 1'b1;
    end else if (page < PG_END) begin
      region = RG_TMR;
      cpu    = tmr_alias_cpu[CPU_W-1:0];
      cpu_ok = (tmr_alias_cpu < N_CPU);
    end
  end

  assign off = win_addr[7:0];
  assign sel = win_addr[SEL_BIT];

endmodule

// File: rtl/prv_scu_regs.sv
module prv_scu_regs #(
  parameter int DATA_W  = 32,
  parameter int NUM_CPU = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              wr,
  input  logic [7:0]        off,
  input  logic              wbit,
  output logic [DATA_W-1:0] rdata,
  output logic              bad
);
  import prv_pkg::*;

  localparam logic [DATA_W-1:0] CFG_WORD =
    DATA_W'(((1 << NUM_CPU) - 1) << 4) | DATA_W'(NUM_CPU - 1);

  logic ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= 1'b0;
    end else if (hit && wr && (off == SCU_CTRL)) begin
      ctrl_q <= wbit;
    end
  end

  always_comb begin
    rdata = '0;
    bad   = 1'b0;
    case (off)
      SCU_CTRL: rdata = {{(DATA_W-1){1'b0}}, ctrl_q};
      SCU_CFG:  rdata = CFG_WORD;
      SCU_STAT: rdata = '0;
      SCU_INV:  rdata = '0;
      default:  bad   = 1'b1;
    endcase
  end

  // R4: invalidate-all writes never disturb the control bit
  assert_inv_no_effect_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && wr && (off == SCU_INV)) |=> $stable(ctrl_q));

  // R10: undecoded offsets return zero data
  assert_bad_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
    bad |-> (rdata == '0));

endmodule

// File: rtl/prv_we_gen.sv
module prv_we_gen #(
  parameter int MAX_CPU = 4,
  parameter int CPU_W   = 2
) (
  input  logic                 wr_irq,
  input  logic                 wr_tmr,
  input  logic [CPU_W-1:0]     irq_idx,
  input  logic [CPU_W:0]       tmr_idx,
  output logic [MAX_CPU-1:0]   irq_we,
  output logic [2*MAX_CPU-1:0] tmr_we
);

  for (genvar g = 0; g < MAX_CPU; g++) begin : g_irq
    assign irq_we[g] = wr_irq && (irq_idx == CPU_W'(g));
  end

  for (genvar t = 0; t < 2 * MAX_CPU; t++) begin : g_tmr
    assign tmr_we[t] = wr_tmr && (tmr_idx == (CPU_W+1)'(t));
  end

endmodule

// File: rtl/prv_rd_mux.sv
module prv_rd_mux #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  prv_pkg::region_e  region,
  input  logic              route_ok,
  input  logic              fault,
  input  logic [DATA_W-1:0] scu_rdata,
  input  logic [DATA_W-1:0] irq_rdata,
  input  logic [DATA_W-1:0] tmr_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              err
);
  import prv_pkg::*;

  logic [DATA_W-1:0] pick;

  always_comb begin
    case (region)
      RG_SCU:  pick = scu_rdata;
      RG_IRQ:  pick = route_ok ? irq_rdata : '0;
      RG_TMR:  pick = route_ok ? tmr_rdata : '0;
      default: pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      err      <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_req ? pick : '0;
      err      <= fault;
    end
  end

  // R11: data bus is quiet whenever no read result is presented
  assert_idle_data_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

  // R9: an unrouted interrupt/timer read returns zero
  assert_unrouted_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !route_ok && (region != RG_SCU)) |=> (rd_data == '0));

endmodule

// File: rtl/prv_window_dec.sv
module prv_window_dec #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int MAX_CPU = 4,
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = (MAX_CPU > 1) ? $clog2(MAX_CPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_en,
  input  logic                 acc_wr,
  input  logic [CPU_W-1:0]     acc_cpu,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [DATA_W-1:0]    acc_wdata,
  input  logic [DATA_W-1:0]    irq_rdata,
  input  logic [DATA_W-1:0]    tmr_rdata,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 acc_err,
  output logic [CPU_W-1:0]     irq_idx,
  output logic [7:0]           irq_off,
  output logic [MAX_CPU-1:0]   irq_we,
  output logic [CPU_W:0]       tmr_idx,
  output logic [3:0]           tmr_off,
  output logic [2*MAX_CPU-1:0] tmr_we,
  output logic [4:0]           tmr_irq_id
);
  import prv_pkg::*;

  localparam logic [4:0] PG_IRQ_ALIAS = 5'd2;
  localparam logic [4:0] PG_TMR_BANK  = 5'(2 + MAX_CPU);
  localparam logic [4:0] PG_TMR_ALIAS = 5'(3 + MAX_CPU);
  localparam logic [4:0] PG_END       = 5'(3 + 2 * MAX_CPU);
  localparam logic [4:0] N_CPU        = 5'(NUM_CPU);

  region_e           region;
  logic [CPU_W-1:0]  dec_cpu;
  logic              dec_ok;
  logic [7:0]        dec_off;
  logic              dec_sel;
  logic [DATA_W-1:0] scu_rdata;
  logic              scu_bad;
  logic              route_ok;
  logic              any_bad;
  logic              wr_irq;
  logic              wr_tmr;
  logic [4:0]        a_page;
  logic [1:0]        unused_bits;

  assign unused_bits = {^acc_addr[ADDR_W-1:12], ^acc_wdata[DATA_W-1:1]};
  assign a_page      = {1'b0, acc_addr[11:8]};

  prv_region_decode #(
    .MAX_CPU (MAX_CPU),
    .NUM_CPU (NUM_CPU),
    .CPU_W   (CPU_W)
  ) u_decode (
    .win_addr (acc_addr[11:0]),
    .req_cpu  (acc_cpu),
    .region   (region),
    .cpu      (dec_cpu),
    .cpu_ok   (dec_ok),
    .off      (dec_off),
    .sel      (dec_sel)
  );

  prv_scu_regs #(
    .DATA_W  (DATA_W),
    .NUM_CPU (NUM_CPU)
  ) u_scu (
    .clk   (clk),
    .rst   (rst),
    .hit   (acc_en && (region == RG_SCU)),
    .wr    (acc_wr),
    .off   (dec_off),
    .wbit  (acc_wdata[0]),
    .rdata (scu_rdata),
    .bad   (scu_bad)
  );

  assign route_ok = dec_ok && ((region == RG_IRQ) || (region == RG_TMR));
  assign any_bad  = (region == RG_NONE) || ((region == RG_SCU) && scu_bad);
  assign wr_irq   = acc_en && acc_wr && (region == RG_IRQ) && dec_ok;
  assign wr_tmr   = acc_en && acc_wr && (region == RG_TMR) && dec_ok;

  assign irq_idx    = (region == RG_IRQ) ? dec_cpu : '0;
  assign irq_off    = dec_off;
  assign tmr_idx    = (region == RG_TMR) ? {dec_cpu, dec_sel} : '0;
  assign tmr_off    = dec_off[TREG_W-1:0];
  assign tmr_irq_id = dec_sel ? PPI_WDOG : PPI_TIMER;

  prv_we_gen #(
    .MAX_CPU (MAX_CPU),
    .CPU_W   (CPU_W)
  ) u_we (
    .wr_irq  (wr_irq),
    .wr_tmr  (wr_tmr),
    .irq_idx (irq_idx),
    .tmr_idx (tmr_idx),
    .irq_we  (irq_we),
    .tmr_we  (tmr_we)
  );

  prv_rd_mux #(
    .DATA_W (DATA_W)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (acc_en && !acc_wr),
    .region    (region),
    .route_ok  (route_ok),
    .fault     (acc_en && any_bad),
    .scu_rdata (scu_rdata),
    .irq_rdata (irq_rdata),
    .tmr_rdata (tmr_rdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .err       (acc_err)
  );

  // R5: at most one interrupt slot written, and only by a write strobe
  assert_irq_we_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_we) && ((|irq_we) -> (acc_en && acc_wr)));

  // R7: at most one timer instance written, and only by a write strobe
  assert_tmr_we_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tmr_we) && ((|tmr_we) -> (acc_en && acc_wr)));

  // R8: the reported private interrupt is always the timer or watchdog one
  assert_ppi_range_R8: assert property (@(posedge clk) disable iff (rst)
    (tmr_irq_id == 5'd29) || (tmr_irq_id == 5'd30));

  // R9: aliases of absent CPUs never write
  assert_alias_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_en && (((a_page >= PG_IRQ_ALIAS) && (a_page < PG_TMR_BANK) &&
                 ((a_page - PG_IRQ_ALIAS) >= N_CPU)) ||
                ((a_page >= PG_TMR_ALIAS) && (a_page < PG_END) &&
                 ((a_page - PG_TMR_ALIAS) >= N_CPU))))
    |-> ((irq_we == '0) && (tmr_we == '0)));

  // R10: error only follows an access to page 0 or past the map
  assert_err_origin_R10: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> ($past(acc_en) && (($past(a_page) == 5'd0) ||
                                   ($past(a_page) >= PG_END))));

  // R10: nothing past the map is written
  assert_no_we_past_map_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_en && (a_page >= PG_END)) |-> ((irq_we == '0) && (tmr_we == '0)));

  // R2: snoop-control word reads with only bit 0 possibly set
  assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ($past(acc_addr[11:0]) == 12'h000)) |-> (rd_data[DATA_W-1:1] == '0));

endmodule

// File: tb/test_prv_window_dec.sv
`timescale 1ns/1ps
module test_prv_window_dec;

  localparam int NCPU = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [1:0]  acc_cpu = '0;
  logic [31:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] irq_rdata;
  logic [31:0] tmr_rdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        acc_err;
  logic [1:0]  irq_idx;
  logic [7:0]  irq_off;
  logic [3:0]  irq_we;
  logic [2:0]  tmr_idx;
  logic [3:0]  tmr_off;
  logic [7:0]  tmr_we;
  logic [4:0]  tmr_irq_id;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0]  c_irq_we;
  logic [1:0]  c_irq_idx;
  logic [7:0]  c_irq_off;
  logic [7:0]  c_tmr_we;
  logic [2:0]  c_tmr_idx;
  logic [3:0]  c_tmr_off;
  logic [4:0]  c_ppi;
  logic        c_rv;
  logic [31:0] c_rd;
  logic        c_err;

  always #4 clk = ~clk;

  prv_window_dec #(.NUM_CPU(NCPU)) i_prv_window_dec (
    .clk (clk), .rst (rst), .acc_en (acc_en), .acc_wr (acc_wr),
    .acc_cpu (acc_cpu), .acc_addr (acc_addr), .acc_wdata (acc_wdata),
    .irq_rdata (irq_rdata), .tmr_rdata (tmr_rdata),
    .rd_valid (rd_valid), .rd_data (rd_data), .acc_err (acc_err),
    .irq_idx (irq_idx), .irq_off (irq_off), .irq_we (irq_we),
    .tmr_idx (tmr_idx), .tmr_off (tmr_off), .tmr_we (tmr_we),
    .tmr_irq_id (tmr_irq_id)
  );

  // Register stubs for the interrupt interfaces and timer instances
  logic [31:0] irq_store [4];
  logic [31:0] tmr_store [8];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) irq_store[i] <= 32'hA000_0000 | (i << 16);
      for (int i = 0; i < 8; i++) tmr_store[i] <= 32'hB000_0000 | (i << 16);
    end else begin
      for (int i = 0; i < 4; i++) if (irq_we[i]) irq_store[i] <= acc_wdata;
      for (int i = 0; i < 8; i++) if (tmr_we[i]) tmr_store[i] <= acc_wdata;
    end
  end

  assign irq_rdata = irq_store[irq_idx] ^ {24'h0, irq_off};
  assign tmr_rdata = tmr_store[tmr_idx] ^ {28'h0, tmr_off};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] cpu,
                        input logic [31:0] addr, input logic [31:0] wd);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_cpu = cpu; acc_addr = addr; acc_wdata = wd;
    #1;
    c_irq_we = irq_we; c_irq_idx = irq_idx; c_irq_off = irq_off;
    c_tmr_we = tmr_we; c_tmr_idx = tmr_idx; c_tmr_off = tmr_off; c_ppi = tmr_irq_id;
    @(posedge clk);
    #1;
    c_rv = rd_valid; c_rd = rd_data; c_err = acc_err;
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic idle_check(input string req);
    @(posedge clk);
    #1;
    chk(req, "idle rd_valid", {31'b0, rd_valid}, 32'd0);
    chk(req, "idle rd_data", rd_data, 32'd0);
    chk(req, "idle acc_err", {31'b0, acc_err}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R11", "reset rd_valid", {31'b0, rd_valid}, 32'd0);
    chk("R10", "reset acc_err", {31'b0, acc_err}, 32'd0);
    access(1'b0, 2'd0, 32'h000, 32'h0);
    chk("R2", "ctrl after reset", c_rd, 32'h0);
    chk("R11", "rd_valid after read", {31'b0, c_rv}, 32'd1);
  endtask

  task automatic t_scu;
    access(1'b1, 2'd1, 32'h000, 32'hFFFF_FFFF);
    chk("R11", "write gives no rd_valid", {31'b0, c_rv}, 32'd0);
    access(1'b0, 2'd1, 32'h000, 32'h0);
    chk("R2", "ctrl keeps bit0 only", c_rd, 32'h1);
    access(1'b0, 2'd0, 32'h004, 32'h0);
    chk("R3", "config word N=3", c_rd, 32'h72);
    chk("R10", "config no error", {31'b0, c_err}, 32'd0);
    access(1'b0, 2'd0, 32'h008, 32'h0);
    chk("R4", "cpu status zero", c_rd, 32'h0);
    access(1'b0, 2'd0, 32'h00C, 32'h0);
    chk("R4", "invalidate reads zero", c_rd, 32'h0);
    access(1'b1, 2'd0, 32'h00C, 32'h0);
    access(1'b0, 2'd0, 32'h000, 32'h0);
    chk("R4", "ctrl unchanged by invalidate", c_rd, 32'h1);
    access(1'b1, 2'd0, 32'hFFFF_F000, 32'h0);
    access(1'b0, 2'd0, 32'h000, 32'h0);
    chk("R1", "upper bits ignored on ctrl write", c_rd, 32'h0);
  endtask

  task automatic t_irq;
    access(1'b0, 2'd2, 32'h134, 32'h0);
    chk("R5", "banked irq_idx", {30'b0, c_irq_idx}, 32'd2);
    chk("R5", "banked irq_off", {24'b0, c_irq_off}, 32'h34);
    chk("R5", "banked read data", c_rd, 32'hA002_0034);
    access(1'b0, 2'd0, 32'h7654_3134, 32'h0);
    chk("R1", "upper address bits ignored", c_rd, 32'hA000_0034);
    access(1'b1, 2'd1, 32'h1F0, 32'hDEAD_0001);
    chk("R5", "banked irq_we", {28'b0, c_irq_we}, 32'b0010);
    chk("R5", "no timer we on irq write", {24'b0, c_tmr_we}, 32'd0);
    access(1'b0, 2'd0, 32'h300, 32'h0);
    chk("R6", "alias cpu1 idx", {30'b0, c_irq_idx}, 32'd1);
    chk("R6", "alias cpu1 sees banked write", c_rd, 32'hDEAD_0001);
    access(1'b0, 2'd0, 32'h4C8, 32'h0);
    chk("R6", "alias cpu2 idx", {30'b0, c_irq_idx}, 32'd2);
    chk("R6", "alias cpu2 data", c_rd, 32'hA002_00C8);
    access(1'b1, 2'd1, 32'h200, 32'h0000_5555);
    chk("R6", "alias cpu0 irq_we", {28'b0, c_irq_we}, 32'b0001);
  endtask

  task automatic t_tmr;
    access(1'b0, 2'd1, 32'h620, 32'h0);
    chk("R7", "banked watchdog idx", {29'b0, c_tmr_idx}, 32'd3);
    chk("R7", "banked watchdog off", {28'b0, c_tmr_off}, 32'd0);
    chk("R8", "watchdog interrupt id", {27'b0, c_ppi}, 32'd30);
    chk("R7", "watchdog read data", c_rd, 32'hB003_0000);
    access(1'b0, 2'd1, 32'h60C, 32'h0);
    chk("R7", "banked timer idx", {29'b0, c_tmr_idx}, 32'd2);
    chk("R7", "banked timer off", {28'b0, c_tmr_off}, 32'hC);
    chk("R8", "timer interrupt id", {27'b0, c_ppi}, 32'd29);
    chk("R7", "timer read data", c_rd, 32'hB002_000C);
    access(1'b1, 2'd0, 32'h924, 32'h1234_5678);
    chk("R7", "alias cpu2 watchdog we", {24'b0, c_tmr_we}, 32'b0010_0000);
    chk("R7", "alias cpu2 watchdog off", {28'b0, c_tmr_off}, 32'd4);
    chk("R7", "no irq we on timer write", {28'b0, c_irq_we}, 32'd0);
    access(1'b0, 2'd2, 32'h620, 32'h0);
    chk("R7", "banked read of aliased write", c_rd, 32'h1234_5678);
  endtask

  task automatic t_alias_out;
    access(1'b0, 2'd0, 32'h510, 32'h0);
    chk("R9", "irq alias cpu3 reads zero", c_rd, 32'h0);
    chk("R9", "irq alias cpu3 no error", {31'b0, c_err}, 32'd0);
    access(1'b1, 2'd0, 32'h500, 32'hFFFF_FFFF);
    chk("R9", "irq alias cpu3 no we", {28'b0, c_irq_we}, 32'd0);
    access(1'b0, 2'd3, 32'h100, 32'h0);
    chk("R9", "cpu3 irq slot untouched", c_rd, 32'hA003_0000);
    access(1'b1, 2'd0, 32'hA20, 32'hFFFF_FFFF);
    chk("R9", "timer alias cpu3 no we", {24'b0, c_tmr_we}, 32'd0);
    access(1'b0, 2'd0, 32'hA20, 32'h0);
    chk("R9", "timer alias cpu3 reads zero", c_rd, 32'h0);
    access(1'b0, 2'd3, 32'h620, 32'h0);
    chk("R9", "cpu3 watchdog untouched", c_rd, 32'hB007_0000);
  endtask

  task automatic t_undecoded;
    access(1'b0, 2'd0, 32'h010, 32'h0);
    chk("R10", "bad scu offset reads zero", c_rd, 32'h0);
    chk("R10", "bad scu offset error", {31'b0, c_err}, 32'd1);
    idle_check("R10");
    access(1'b1, 2'd0, 32'hB00, 32'hFFFF_FFFF);
    chk("R10", "past map no irq we", {28'b0, c_irq_we}, 32'd0);
    chk("R10", "past map no tmr we", {24'b0, c_tmr_we}, 32'd0);
    chk("R10", "past map write error", {31'b0, c_err}, 32'd1);
    access(1'b0, 2'd2, 32'hFFC, 32'h0);
    chk("R10", "top of window reads zero", c_rd, 32'h0);
    chk("R10", "top of window error", {31'b0, c_err}, 32'd1);
    idle_check("R10");
  endtask

  task automatic t_timing;
    access(1'b0, 2'd0, 32'h004, 32'h0);
    chk("R11", "read result next cycle", c_rd, 32'h72);
    chk("R11", "rd_valid next cycle", {31'b0, c_rv}, 32'd1);
    idle_check("R11");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_scu();
    t_irq();
    t_tmr();
    t_alias_out();
    t_undecoded();
    t_timing();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule